// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Builder

This block turns a stream of scatter segments, each a 32-bit byte address and a byte length, into the descriptor table that a scatter-gather DMA walker later fetches. The walker can only start transfers on 32-bit boundaries. When a segment starts mid-word, the builder first emits a short descriptor. That descriptor points at a 4-byte slot in a bounce area and carries the one to three leading bytes. The builder then emits a descriptor for the aligned rest of the segment. After the segment flagged as last, it writes a terminating entry. Moving data into or out of the bounce area is left to other logic.

Segments arrive on a valid/ready handshake. Descriptors leave on a write port that gives the entry index and the two 32-bit words of each entry, at most one entry per cycle. The bounce area base is a static input. Slots inside it are handed out in order, one per split. The entry count and an overflow flag report on the table. A segment that is too long, or one too many, aborts the table. The rest of that table's segments are then discarded.

Top module: `sg_desc_builder`

## Requirements
- R1: After reset, seg_ready_o is 1, wr_en_o, done_o and overflow_o are 0, and desc_count_o is 0.
- R2: For a segment at address A with length L, the head count h is (4 - A[1:0]) mod 4, limited to L. When h is nonzero, a transfer entry with address bounce_base_i + 4*k and length h is written first. Here k is the number of splits made earlier in the same table, and each split takes the next 4-byte slot.
- R3: The body entry has address A + h and length L - h. With a 4-byte-aligned bounce base, every transfer entry address is 4-byte aligned.
- R4: A body of length 0 writes no entry. An aligned zero-length segment writes nothing at all, and a segment shorter than its head count writes only the head entry.
- R5: Entry format: wr_hi_o holds the address. wr_lo_o holds {length[15:0], 8'h00, attribute[7:0]}, and the transfer attribute is 8'h21. A length of 65536 is encoded as 16'h0000.
- R6: After the last segment's entries, one terminator is written with wr_hi_o = 0 and wr_lo_o = 32'h0000_0003. done_o is 1 in exactly that write cycle.
- R7: Entry indices on wr_idx_o run from 0 upward, with no gaps, in segment order (head before body). desc_count_o then holds the number of entries in the table. The first segment after a finished or aborted table starts again at index 0 and bounce slot 0.
- R8: A segment longer than 65536 bytes sets overflow_o and writes nothing. Later segments are accepted and dropped, up to and including the one flagged last. overflow_o stays 1 until the first segment of the next table is accepted.
- R9: A 129th segment (MAX_SEGS + 1) in one table sets overflow_o in the same way as R8. The 128 segments before it are processed normally.
- R10: A segment is taken on a cycle with seg_valid_i and seg_ready_o both 1. seg_ready_o is never 1 in a cycle that writes an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| seg_valid_i | input | 1 | Segment offered |
| seg_ready_o | output | 1 | Segment can be taken |
| seg_addr_i | input | 32 | Segment byte address |
| seg_len_i | input | 17 | Segment byte length |
| seg_last_i | input | 1 | Segment closes the table |
| bounce_base_i | input | 32 | Byte address of bounce slot 0 |
| wr_en_o | output | 1 | Entry write strobe |
| wr_idx_o | output | 9 | Entry index in the table |
| wr_lo_o | output | 32 | Entry low word: length, attribute |
| wr_hi_o | output | 32 | Entry high word: address |
| desc_count_o | output | 9 | Entries written in current table |
| overflow_o | output | 1 | Table aborted |
| done_o | output | 1 | Terminator written this cycle |

## Verification
The checker watches every cycle. It checks that each written attribute is one of the two legal codes and that the terminator is all-zero apart from its attribute. It also checks that done_o coincides with the terminator write, that consecutive writes step the index by one, and that an aborted table writes nothing. Further checks are that transfer addresses stay word-aligned and that ready never overlaps a write. The actual head and body arithmetic cannot be seen from a single cycle, so the bench scenarios cover it. These scenarios include head-limited short segments, bounce slot order, length 65536 encoding, and restart of index and slot after a table ends. They also cover both overflow causes and the dropping of segments after an abort.

// File: rtl/sgb_pkg.sv
package sgb_pkg;
  localparam logic [7:0] ATTR_XFER = 8'h21;
  localparam logic [7:0] ATTR_END  = 8'h03;
  localparam int         FIELD_W   = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HEAD,
    ST_BODY,
    ST_END,
    ST_DRAIN
  } sgb_state_e;
endpackage

// File: rtl/sgb_seg_split.sv
module sgb_seg_split #(
  parameter int LEN_W = 17
) (
  input  logic [31:0]      addr_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [LEN_W-1:0] head_o,
  output logic [31:0]      body_addr_o,
  output logic [LEN_W-1:0] body_len_o
);
  logic [1:0]       lead;
  logic [LEN_W-1:0] lead_w;

  always_comb begin
    lead        = 2'd0 - addr_i[1:0];  // bytes up to next word boundary
    lead_w      = LEN_W'(lead);
    head_o      = (len_i < lead_w) ? len_i : lead_w;
    body_addr_o = addr_i + 32'(head_o);
    body_len_o  = len_i - head_o;
  end
endmodule

// File: rtl/sgb_desc_pack.sv
module sgb_desc_pack
  import sgb_pkg::*;
(
  input  logic               is_end_i,
  input  logic [31:0]        addr_i,
  input  logic [FIELD_W-1:0] len_i,
  output logic [31:0]        hi_o,
  output logic [31:0]        lo_o
);
  always_comb begin
    if (is_end_i) begin
      hi_o = '0;
      lo_o = {24'h0, ATTR_END};
    end else begin
      hi_o = addr_i;
      lo_o = {len_i, 8'h00, ATTR_XFER};
    end
  end
endmodule

// File: rtl/sg_desc_builder.sv
module sg_desc_builder
  import sgb_pkg::*;
#(
  parameter  int MAX_SEGS = 128,
  parameter  int MAX_LEN  = 65536,
  localparam int LEN_W    = $clog2(MAX_LEN + 1),
  localparam int CNT_W    = $clog2(MAX_SEGS + 1),
  localparam int IDX_W    = $clog2(2 * MAX_SEGS + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             seg_valid_i,
  output logic             seg_ready_o,
  input  logic [31:0]      seg_addr_i,
  input  logic [LEN_W-1:0] seg_len_i,
  input  logic             seg_last_i,
  input  logic [31:0]      bounce_base_i,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [31:0]      wr_lo_o,
  output logic [31:0]      wr_hi_o,
  output logic [IDX_W-1:0] desc_count_o,
  output logic             overflow_o,
  output logic             done_o
);
  sgb_state_e       state_q;
  logic [31:0]      addr_q;
  logic [LEN_W-1:0] len_q;
  logic             last_q;
  logic [CNT_W-1:0] seg_cnt_q, split_cnt_q;
  logic [IDX_W-1:0] desc_cnt_q;
  logic             fresh_q, ovf_q;

  logic [LEN_W-1:0] head, body_len;
  logic [31:0]      body_addr, slot_addr, pk_addr;
  logic [FIELD_W-1:0] pk_len;
  logic             pk_end, accept, bad;
  logic [CNT_W-1:0] seg_eff, split_eff;
  logic [IDX_W-1:0] desc_eff;

  sgb_seg_split #(.LEN_W(LEN_W)) u_split (
    .addr_i      (addr_q),
    .len_i       (len_q),
    .head_o      (head),
    .body_addr_o (body_addr),
    .body_len_o  (body_len)
  );

  sgb_desc_pack u_pack (
    .is_end_i (pk_end),
    .addr_i   (pk_addr),
    .len_i    (pk_len),
    .hi_o     (wr_hi_o),
    .lo_o     (wr_lo_o)
  );

  always_comb begin
    seg_ready_o = (state_q == ST_IDLE) || (state_q == ST_DRAIN);
    accept      = seg_valid_i && seg_ready_o;
    seg_eff     = fresh_q ? '0 : seg_cnt_q;
    split_eff   = fresh_q ? '0 : split_cnt_q;
    desc_eff    = fresh_q ? '0 : desc_cnt_q;
    bad         = (seg_len_i > LEN_W'(MAX_LEN)) || (seg_eff == CNT_W'(MAX_SEGS));
    slot_addr   = bounce_base_i + (32'(split_cnt_q) << 2);
    wr_en_o     = 1'b0;
    pk_end      = 1'b0;
    pk_addr     = body_addr;
    pk_len      = body_len[FIELD_W-1:0];
    unique case (state_q)
      ST_HEAD: begin
        wr_en_o = (head != '0);
        pk_addr = slot_addr;
        pk_len  = head[FIELD_W-1:0];
      end
      ST_BODY: wr_en_o = (body_len != '0);
      ST_END: begin
        wr_en_o = 1'b1;
        pk_end  = 1'b1;
      end
      default: ;
    endcase
  end

  assign wr_idx_o     = desc_cnt_q;
  assign desc_count_o = desc_cnt_q;
  assign overflow_o   = ovf_q;
  assign done_o       = (state_q == ST_END);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      len_q       <= '0;
      last_q      <= 1'b0;
      seg_cnt_q   <= '0;
      split_cnt_q <= '0;
      desc_cnt_q  <= '0;
      fresh_q     <= 1'b1;
      ovf_q       <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          ovf_q       <= bad;
          seg_cnt_q   <= seg_eff + CNT_W'(1);
          split_cnt_q <= split_eff;
          desc_cnt_q  <= desc_eff;
          if (bad) begin
            fresh_q <= seg_last_i;
            state_q <= seg_last_i ? ST_IDLE : ST_DRAIN;
          end else begin
            fresh_q <= 1'b0;
            addr_q  <= seg_addr_i;
            len_q   <= seg_len_i;
            last_q  <= seg_last_i;
            state_q <= ST_HEAD;
          end
        end
        ST_HEAD: begin
          if (wr_en_o) begin
            desc_cnt_q  <= desc_cnt_q + IDX_W'(1);
            split_cnt_q <= split_cnt_q + CNT_W'(1);
          end
          state_q <= ST_BODY;
        end
        ST_BODY: begin
          if (wr_en_o) desc_cnt_q <= desc_cnt_q + IDX_W'(1);
          state_q <= last_q ? ST_END : ST_IDLE;
        end
        ST_END: begin
          desc_cnt_q <= desc_cnt_q + IDX_W'(1);
          fresh_q    <= 1'b1;
          state_q    <= ST_IDLE;
        end
        ST_DRAIN: if (accept && seg_last_i) begin
          fresh_q <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sg_desc_builder_chk.sv
module sg_desc_builder_chk #(
  parameter int MAX_SEGS = 128,
  parameter int IDX_W    = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             seg_ready_o,
  input logic             wr_en_o,
  input logic [IDX_W-1:0] wr_idx_o,
  input logic [31:0]      wr_lo_o,
  input logic [31:0]      wr_hi_o,
  input logic [31:0]      bounce_base_i,
  input logic             overflow_o,
  input logic             done_o
);
  a_r5_attr_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_lo_o[7:0] == 8'h21 || wr_lo_o[7:0] == 8'h03));

  a_r6_end_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_lo_o[7:0] == 8'h03) |-> (wr_hi_o == 32'h0 && wr_lo_o[31:8] == 24'h0));

  a_r6_done_is_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (wr_en_o && wr_lo_o[7:0] == 8'h03));

  a_r6_end_is_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_lo_o[7:0] == 8'h03) |-> done_o);

  a_r3_xfer_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_lo_o[7:0] == 8'h21 && bounce_base_i[1:0] == 2'b00) |-> wr_hi_o[1:0] == 2'b00);

  a_r7_idx_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && $past(wr_en_o) && !$past(done_o)) |-> wr_idx_o == $past(wr_idx_o) + 1'b1);

  a_r7_idx_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (32'(wr_idx_o) < 2 * MAX_SEGS + 1));

  a_r8_quiet_on_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> !wr_en_o);

  a_r10_ready_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_ready_o |-> !wr_en_o);
endmodule

bind sg_desc_builder sg_desc_builder_chk #(.MAX_SEGS(MAX_SEGS), .IDX_W(IDX_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .seg_ready_o   (seg_ready_o),
  .wr_en_o       (wr_en_o),
  .wr_idx_o      (wr_idx_o),
  .wr_lo_o       (wr_lo_o),
  .wr_hi_o       (wr_hi_o),
  .bounce_base_i (bounce_base_i),
  .overflow_o    (overflow_o),
  .done_o        (done_o)
);

// File: tb/sg_desc_builder_tb.sv
module sg_desc_builder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_SEGS   = 128;
  localparam int MAX_LEN    = 65536;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        seg_valid_i = 1'b0;
  logic        seg_ready_o;
  logic [31:0] seg_addr_i = '0;
  logic [16:0] seg_len_i = '0;
  logic        seg_last_i = 1'b0;
  logic [31:0] bounce_base_i = 32'h0009_0000;
  logic        wr_en_o;
  logic [8:0]  wr_idx_o;
  logic [31:0] wr_lo_o, wr_hi_o;
  logic [8:0]  desc_count_o;
  logic        overflow_o, done_o;

  int n_vec = 0;
  int n_bad = 0;

  // scoreboard entry: {idx, hi, lo, done}
  logic [73:0] exp_q[$];

  // model state
  int  m_idx = 0, m_split = 0, m_seg = 0;
  bit  m_fresh = 1, m_drop = 0, m_ovf = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sg_desc_builder u_dut (
    .clk_i, .rst_ni, .seg_valid_i, .seg_ready_o, .seg_addr_i, .seg_len_i,
    .seg_last_i, .bounce_base_i, .wr_en_o, .wr_idx_o, .wr_lo_o, .wr_hi_o,
    .desc_count_o, .overflow_o, .done_o
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic push_exp(input int idx, input logic [31:0] hi, input logic [31:0] lo, input bit dn);
    exp_q.push_back({9'(idx), hi, lo, dn});
  endtask

  task automatic send(input logic [31:0] a, input int len, input bit last);
    int head, body;
    // model (R2 R3 R4 R5 R6 R7 R8 R9)
    if (m_drop) begin
      if (last) begin m_drop = 0; m_fresh = 1; end
    end else begin
      if (m_fresh) begin m_idx = 0; m_split = 0; m_seg = 0; m_fresh = 0; end
      m_ovf = (len > MAX_LEN) || (m_seg == MAX_SEGS);
      if (m_ovf) begin
        if (last) m_fresh = 1; else m_drop = 1;
      end else begin
        m_seg++;
        head = (4 - (a % 4)) % 4;
        if (head > len) head = len;
        body = len - head;
        if (head != 0) begin
          push_exp(m_idx, bounce_base_i + 32'(4 * m_split), {16'(head), 8'h00, 8'h21}, 0);
          m_idx++; m_split++;
        end
        if (body != 0) begin
          push_exp(m_idx, a + 32'(head), {16'(body), 8'h00, 8'h21}, 0);
          m_idx++;
        end
        if (last) begin
          push_exp(m_idx, 32'h0, 32'h0000_0003, 1);
          m_idx++; m_fresh = 1;
        end
      end
    end
    // drive
    @(negedge clk_i);
    seg_valid_i = 1'b1; seg_addr_i = a; seg_len_i = 17'(len); seg_last_i = last;
    while (!seg_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    seg_valid_i = 1'b0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk_i);
    chk(exp_q.size() == 0, "R7 pending entries", exp_q.size(), 0);
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (wr_en_o) begin
        if (exp_q.size() == 0) begin
          chk(0, "R4/R8 unexpected write", {wr_hi_o, wr_lo_o}, 0);
        end else begin
          logic [73:0] e;
          e = exp_q.pop_front();
          chk(wr_idx_o == e[73:65], "R7 index", wr_idx_o, e[73:65]);
          chk(wr_hi_o == e[64:33], "R2/R3 address", wr_hi_o, e[64:33]);
          chk(wr_lo_o == e[32:1], "R5 low word", wr_lo_o, e[32:1]);
          chk(done_o == e[0], "R6 done", done_o, e[0]);
        end
      end else if (done_o) begin
        chk(0, "R6 done without write", 1, 0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(seg_ready_o == 1'b1, "R1 ready", seg_ready_o, 1);
    chk(wr_en_o == 1'b0, "R1 wr_en", wr_en_o, 0);
    chk(done_o == 1'b0, "R1 done", done_o, 0);
    chk(overflow_o == 1'b0, "R1 overflow", overflow_o, 0);
    chk(desc_count_o == 9'd0, "R1 count", desc_count_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // Table A: mix of aligned, split, head-only, empty and full-size (R2 R3 R4 R5 R6)
    send(32'h0000_1000, 64, 0);
    send(32'h0000_2001, 10, 0);
    send(32'h0000_3003, 1, 0);
    send(32'h0000_4002, 1, 0);
    send(32'h0000_5000, 0, 0);
    send(32'h0000_6002, 65536, 1);
    settle();
    chk(desc_count_o == 9'(m_idx), "R7 count table A", desc_count_o, m_idx);
    chk(overflow_o == 1'b0, "R8 no overflow A", overflow_o, 0);

    // Table B: restarts index and bounce slot (R7); aligned 65536 encodes 0 (R5)
    send(32'h0000_7001, 65536, 0);
    send(32'h0000_8000, 65536, 1);
    settle();
    chk(desc_count_o == 9'(m_idx), "R7 count table B", desc_count_o, m_idx);

    // Table C: over-long segment aborts, rest dropped (R8)
    send(32'h0000_0100, 8, 0);
    send(32'h0000_0201, 65537, 0);
    send(32'h0000_0302, 4, 0);
    send(32'h0000_0300, 4, 1);
    settle();
    chk(overflow_o == 1'b1, "R8 overflow held", overflow_o, 1);
    chk(desc_count_o == 9'(m_idx), "R8 count at abort", desc_count_o, m_idx);

    // Table D: overflow cleared by next table (R8)
    send(32'h0000_0403, 5, 1);
    settle();
    chk(overflow_o == 1'b0, "R8 overflow cleared", overflow_o, 0);

    // Table E: 129th segment overflows (R9)
    for (int i = 0; i < MAX_SEGS; i++) send(32'h0001_0000 + 32'(i * 16) + 32'(i % 4), 8, 0);
    send(32'h0002_0000, 4, 1);
    settle();
    chk(overflow_o == 1'b1, "R9 segment limit", overflow_o, 1);
    chk(desc_count_o == 9'(m_idx), "R9 count", desc_count_o, m_idx);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule